// File: doc/BRIEF.md
# Four-Channel Programmed DMA Controller

The block is a four-channel DMA controller core. A host CPU programs it through a byte-wide register port, and it moves data one unit at a time for peripherals that raise a request line. Each channel holds a 16-bit start address and a 16-bit count. The count is written as the transfer length minus one. Each channel also holds a mode and a mask bit. Multi-byte registers are reached through one shared byte pointer that toggles on every access, and a dedicated register returns the pointer to the low byte.

When an unmasked channel sees its request, the controller grants it by fixed priority, with channel 0 the highest. It raises that channel's acknowledge and presents the current address and direction on a simple request/grant memory handshake. When the memory grants the cycle, the address steps up by one and the count steps down by one. On the unit where the count passes from 0 to 0xFFFF, the terminal-count output is high during the transfer and the channel's status bit is set.

At that point an auto-initialising channel reloads its start values and stays unmasked. Any other channel is left at count 0xFFFF and masks itself. A channel in cascade mode makes no memory cycles: it only passes its request through to its acknowledge, so an external bus master can take over.

Register map (`host_addr`):
- 0x0 to 0x7: channel registers. Bits [2:1] select the channel and bit 0 selects address (0) or count (1).
- 0x8: status, read only.
- 0x9: single mask, write only.
- 0xA: mode, write only.
- 0xB: clear the byte pointer, on any write.

Top module: `dma4_core`

## Requirements
- R1: After reset, every channel is masked, `dack` is 0, `mem_req` and `tc` are 0, and the status register reads 0x00.
- R2: Each write or read of a channel register (0x0 to 0x7) toggles one shared byte pointer. The pointer starts at the low byte, so the first access is to bits [7:0] and the next to bits [15:8]. Any write to 0xB returns the pointer to the low byte.
- R3: Writing the address (register 2n) or count (register 2n+1) of channel n loads both the start value and the current value. Reads of the same register return the current value, low byte first.
- R4: When several unmasked channels request at once, the lowest-numbered channel is served first, and `dack` never has more than one bit set.
- R5: A masked channel ignores its `dreq`. A write to 0x9 names the channel in bits [1:0]; bit 2 set to 1 masks the channel and bit 2 cleared to 0 unmasks it.
- R6: A write to 0xA names the channel in bits [1:0]. Bit 2 is the direction (1 = write to memory), bit 3 enables auto-initialise and bit 4 selects cascade. On a transfer, `mem_req`, `mem_addr` (current address), `mem_write` and `dack` are held until `mem_gnt` is sampled high. After that grant the address has risen by 1 and the count has fallen by 1.
- R7: A programmed count C yields C+1 transfers at ascending addresses. `tc` is high together with `mem_req` on the last of them only.
- R8: Without auto-initialise, after the last transfer the count reads 0xFFFF, the address reads the start address plus C+1, and the channel masks itself.
- R9: With auto-initialise, after the last transfer the current address and count reload their start values and the channel stays unmasked.
- R10: Status bits [3:0] hold one terminal-count flag per channel (bit n = channel n), and bits [7:4] read 0. A flag is set by that channel's last transfer and cleared by reading the status register.
- R11: An unmasked cascade channel's `dack` rises one clock after its `dreq` rises and falls one clock after `dreq` falls. No `mem_req` is made and the channel's address is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after `host_re` |
| dreq | input | NCH | Per-channel transfer request |
| dack | output | NCH | Per-channel acknowledge, one-hot or zero |
| mem_req | output | 1 | Memory cycle request |
| mem_addr | output | AW | Memory address of the current transfer |
| mem_write | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_gnt | input | 1 | Memory grant; completes the transfer when sampled high |
| tc | output | 1 | Terminal count, high during a channel's last transfer |

## Verification
The outputs are registered, so timing is counted in clock edges from when a stimulus is sampled:
- A request sampled while the controller is idle shows `dack` and `mem_req` after that same edge.
- A grant sampled on an edge ends the transfer and updates the address and count on that edge. The next request can be taken one idle cycle later.
- A host read presents its byte after the edge that samples `host_re`, and a status read clears the flags on that same edge.

The bench drives every input on the falling edge and samples on the next falling edge, so each result is read exactly one edge after its cause. The memory-side monitor compares each request against the queue of expected transfers at the falling edge where it first appears. It then grants that request for exactly one edge, and after the final expected item it drops the device's request in that same half cycle.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_CASC} dma_state_t;

  typedef struct packed {
    logic cascade;
    logic autoinit;
    logic mem_wr;
  } chan_mode_t;

  localparam logic [3:0] REG_STATUS = 4'h8;
  localparam logic [3:0] REG_MASK   = 4'h9;
  localparam logic [3:0] REG_MODE   = 4'hA;
  localparam logic [3:0] REG_PTRCLR = 4'hB;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant,
  output logic           any
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma4_channel.sv
module dma4_channel
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr_lo,
  input  logic          wr_addr_hi,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic [7:0]    wdata,
  input  logic          mode_we,
  input  chan_mode_t    mode_in,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output chan_mode_t    mode,
  output logic          masked
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      masked    <= 1'b1;
    end else begin
      if (step) begin
        if (cur_cnt == '0) begin
          if (mode.autoinit) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
          end else begin
            cur_addr <= cur_addr + 1'b1;
            cur_cnt  <= '1;
            masked   <= 1'b1;
          end
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
      if (wr_addr_lo) begin
        base_addr[7:0] <= wdata;
        cur_addr[7:0]  <= wdata;
      end
      if (wr_addr_hi) begin
        base_addr[AW-1:8] <= wdata[AW-9:0];
        cur_addr[AW-1:8]  <= wdata[AW-9:0];
      end
      if (wr_cnt_lo) begin
        base_cnt[7:0] <= wdata;
        cur_cnt[7:0]  <= wdata;
      end
      if (wr_cnt_hi) begin
        base_cnt[CW-1:8] <= wdata[CW-9:0];
        cur_cnt[CW-1:8]  <= wdata[CW-9:0];
      end
      if (mode_we)  mode   <= mode_in;
      if (mask_set) masked <= 1'b1;
      if (mask_clr) masked <= 1'b0;
    end
  end

  // R8: a non-reloading channel masks itself after its last unit
  assert_selfmask_R8: assert property (@(posedge clk) disable iff (rst)
    (step && cur_cnt == '0 && !mode.autoinit && !mask_clr) |=> masked);

  // R9: a reloading channel returns to its start count after its last unit
  assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (step && cur_cnt == '0 && mode.autoinit && !wr_cnt_lo && !wr_cnt_hi)
    |=> (cur_cnt == $past(base_cnt)));
endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_we,
  input  logic           host_re,
  input  logic [3:0]     host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_write,
  input  logic           mem_gnt,
  output logic           tc
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  dma_state_t    state;
  logic          byte_hi;
  logic [NCH-1:0] win_q, grant, elig, masked, cnt_zero, step, status_q;
  logic          any_req;
  logic [AW-1:0] cur_addr [NCH];
  logic [CW-1:0] cur_cnt  [NCH];
  chan_mode_t    mode     [NCH];

  logic            ch_hit;
  logic [CH_W-1:0] sel_ch;
  logic            sel_cnt;
  assign ch_hit  = (host_addr[3] == 1'b0);
  assign sel_ch  = host_addr[CH_W:1];
  assign sel_cnt = host_addr[0];

  chan_mode_t mode_wr;
  assign mode_wr = '{cascade: host_wdata[4], autoinit: host_wdata[3], mem_wr: host_wdata[2]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic reg_sel, mask_wr;
    assign reg_sel = host_we && ch_hit && (sel_ch == CH_W'(i));
    assign mask_wr = host_we && (host_addr == REG_MASK) && (host_wdata[1:0] == 2'(i));
    assign step[i]     = (state == ST_XFER) && mem_gnt && win_q[i];
    assign cnt_zero[i] = (cur_cnt[i] == '0);
    assign elig[i]     = dreq[i] && !masked[i];

    dma4_channel #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_addr_lo(reg_sel && !sel_cnt && !byte_hi),
      .wr_addr_hi(reg_sel && !sel_cnt &&  byte_hi),
      .wr_cnt_lo (reg_sel &&  sel_cnt && !byte_hi),
      .wr_cnt_hi (reg_sel &&  sel_cnt &&  byte_hi),
      .wdata     (host_wdata),
      .mode_we   (host_we && (host_addr == REG_MODE) && (host_wdata[1:0] == 2'(i))),
      .mode_in   (mode_wr),
      .mask_set  (mask_wr &&  host_wdata[2]),
      .mask_clr  (mask_wr && !host_wdata[2]),
      .step      (step[i]),
      .cur_addr  (cur_addr[i]),
      .cur_cnt   (cur_cnt[i]),
      .mode      (mode[i]),
      .masked    (masked[i])
    );
  end

  dma4_prio #(.NCH(NCH)) u_prio (.req(elig), .grant(grant), .any(any_req));

  logic [AW-1:0] pick_addr;
  logic          pick_zero;
  chan_mode_t    pick_mode;
  always_comb begin
    pick_addr = '0;
    pick_zero = 1'b0;
    pick_mode = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        pick_addr = cur_addr[i];
        pick_zero = cnt_zero[i];
        pick_mode = mode[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      win_q     <= '0;
      dack      <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_write <= 1'b0;
      tc        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (any_req) begin
          win_q <= grant;
          dack  <= grant;
          if (pick_mode.cascade) begin
            state <= ST_CASC;
          end else begin
            state     <= ST_XFER;
            mem_req   <= 1'b1;
            mem_addr  <= pick_addr;
            mem_write <= pick_mode.mem_wr;
            tc        <= pick_zero;
          end
        end
        ST_XFER: if (mem_gnt) begin
          state   <= ST_IDLE;
          dack    <= '0;
          mem_req <= 1'b0;
          tc      <= 1'b0;
        end
        ST_CASC: if ((dreq & win_q) == '0) begin
          state <= ST_IDLE;
          dack  <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic          stat_rd;
  logic [CW-1:0] rd_word;
  assign stat_rd = host_re && (host_addr == REG_STATUS);
  assign rd_word = sel_cnt ? cur_cnt[sel_ch] : CW'(cur_addr[sel_ch]);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_hi    <= 1'b0;
      status_q   <= '0;
      host_rdata <= '0;
    end else begin
      status_q <= (status_q & ~{NCH{stat_rd}}) | (step & cnt_zero);
      if (host_we && host_addr == REG_PTRCLR)    byte_hi <= 1'b0;
      else if ((host_we || host_re) && ch_hit)    byte_hi <= !byte_hi;
      if (host_re) begin
        if (ch_hit)       host_rdata <= byte_hi ? 8'(rd_word >> 8) : rd_word[7:0];
        else if (stat_rd) host_rdata <= 8'(status_q);
        else              host_rdata <= '0;
      end
    end
  end

  // R4: at most one channel acknowledged
  assert_onehot_dack_R4: assert property (@(posedge clk) disable iff (rst) $onehot0(dack));

  // R6: request, address and acknowledge held until granted
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(dack)));

  // R7: terminal count only inside a memory cycle
  assert_tc_in_cycle_R7: assert property (@(posedge clk) disable iff (rst) tc |-> mem_req);

  // R5: a new memory cycle answers a request that was present
  assert_start_on_req_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (($past(dreq) & dack) != '0));
endmodule

// File: tb/dma4_core_tb.sv
`timescale 1ns/1ps
module dma4_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0, host_re = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [3:0] dreq = '0;
  logic [3:0] dack;
  logic       mem_req, mem_write, tc;
  logic [15:0] mem_addr;
  logic       mem_gnt = 1'b0;

  always #2.5 clk = ~clk;

  dma4_core u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dreq(dreq), .dack(dack), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_gnt(mem_gnt), .tc(tc)
  );

  typedef struct {
    int         ch;
    logic [15:0] a;
    bit         w;
    bit         t;
    bit         last;
  } xfer_t;

  xfer_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(int ch, logic [15:0] a, bit w, bit t, bit last);
    xfer_t x;
    x.ch = ch; x.a = a; x.w = w; x.t = t; x.last = last;
    exp_q.push_back(x);
  endtask

  // scoreboard monitor and memory responder
  always @(negedge clk) begin
    if (mem_gnt) begin
      mem_gnt <= 1'b0;
    end else if (!rst && mem_req) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected transfer", {16'h0, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        xfer_t x;
        x = exp_q.pop_front();
        chk("R6 mem_addr", {16'h0, mem_addr}, {16'h0, x.a});
        chk("R6 mem_write", {31'h0, mem_write}, {31'h0, x.w});
        chk("R7 tc", {31'h0, tc}, {31'h0, x.t});
        chk("R4 dack", {28'h0, dack}, 32'(1 << x.ch));
        if (x.last) dreq[x.ch] <= 1'b0;
      end
      mem_gnt <= 1'b1;
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd16(logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'hB, 8'h00);
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic prog(int ch, logic [15:0] a, logic [15:0] c, logic [7:0] md);
    wr(4'hB, 8'h00);
    wr(4'(2*ch), a[7:0]);   wr(4'(2*ch), a[15:8]);
    wr(4'(2*ch+1), c[7:0]); wr(4'(2*ch+1), c[15:8]);
    wr(4'hA, md);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual %0d expected %0d", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    bit          seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dack after reset", {28'h0, dack}, 32'h0);
    chk("R1 mem_req/tc after reset", {30'h0, mem_req, tc}, 32'h0);
    rd(4'h8, b);
    chk("R1 status after reset", {24'h0, b}, 32'h0);

    // R1/R5: channel 0 masked out of reset ignores its request
    dreq[0] = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (mem_req || dack != 0) seen = 1;
    end
    chk("R5 masked after reset ignores dreq", {31'h0, seen}, 32'h0);
    dreq[0] = 1'b0;

    // R2: pointer clear returns to low byte
    wr(4'hB, 8'h00);
    wr(4'h2, 8'hAA);
    wr(4'hB, 8'h00);
    wr(4'h2, 8'h12);
    wr(4'h2, 8'h34);
    rd16(4'h2, v);
    chk("R2 pointer clear then lo/hi write", {16'h0, v}, 32'h3412);
    rd(4'h2, b);
    wr(4'hB, 8'h00);
    rd(4'h2, b);
    chk("R2 read after clear is low byte", {24'h0, b}, 32'h12);

    // R3/R7/R8: channel 1, count 2 -> three writes to memory
    prog(1, 16'h3412, 16'h0002, 8'h05);
    rd16(4'h3, v);
    chk("R3 count readback", {16'h0, v}, 32'h0002);
    push(1, 16'h3412, 1, 0, 0);
    push(1, 16'h3413, 1, 0, 0);
    push(1, 16'h3414, 1, 1, 1);
    wr(4'h9, 8'h01);
    dreq[1] = 1'b1;
    drain();
    rd16(4'h3, v);
    chk("R8 count wraps to FFFF", {16'h0, v}, 32'hFFFF);
    rd16(4'h2, v);
    chk("R8 address after last", {16'h0, v}, 32'h3415);
    rd(4'h8, b);
    chk("R10 status ch1 flag", {24'h0, b}, 32'h02);
    rd(4'h8, b);
    chk("R10 status cleared by read", {24'h0, b}, 32'h0);
    dreq[1] = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (mem_req || dack != 0) seen = 1;
    end
    chk("R8 self-masked channel ignores dreq", {31'h0, seen}, 32'h0);
    dreq[1] = 1'b0;

    // R4: channels 0 and 2 request together
    prog(0, 16'h0100, 16'h0001, 8'h00);
    prog(2, 16'h0200, 16'h0000, 8'h06);
    wr(4'h9, 8'h00);
    wr(4'h9, 8'h02);
    push(0, 16'h0100, 0, 0, 0);
    push(0, 16'h0101, 0, 1, 1);
    push(2, 16'h0200, 1, 1, 1);
    dreq = 4'b0101;
    drain();
    rd(4'h8, b);
    chk("R10 status ch0 and ch2", {24'h0, b}, 32'h05);

    // R5: masking by write, then unmasking
    prog(0, 16'h0300, 16'h0000, 8'h00);
    wr(4'h9, 8'h00);
    wr(4'h9, 8'h04);
    dreq[0] = 1'b1;
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (mem_req) seen = 1;
    end
    chk("R5 mask write blocks dreq", {31'h0, seen}, 32'h0);
    push(0, 16'h0300, 0, 1, 1);
    wr(4'h9, 8'h00);
    drain();
    rd(4'h8, b);

    // R9: auto-initialise on channel 3
    prog(3, 16'h0800, 16'h0001, 8'h0B);
    wr(4'h9, 8'h03);
    push(3, 16'h0800, 0, 0, 0);
    push(3, 16'h0801, 0, 1, 1);
    dreq[3] = 1'b1;
    drain();
    rd16(4'h7, v);
    chk("R9 count reloaded", {16'h0, v}, 32'h0001);
    rd16(4'h6, v);
    chk("R9 address reloaded", {16'h0, v}, 32'h0800);
    rd(4'h8, b);
    chk("R10 status ch3", {24'h0, b}, 32'h08);
    push(3, 16'h0800, 0, 0, 1);
    dreq[3] = 1'b1;
    drain();
    chk("R9 channel stayed unmasked", exp_q.size(), 32'h0);

    // R11: cascade on channel 2
    wr(4'hA, 8'h12);
    wr(4'h9, 8'h02);
    dreq[2] = 1'b1;
    @(negedge clk);
    chk("R11 dack follows dreq", {28'h0, dack}, 32'h4);
    chk("R11 no mem_req in cascade", {31'h0, mem_req}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 dack held", {28'h0, dack}, 32'h4);
    dreq[2] = 1'b0;
    @(negedge clk);
    chk("R11 dack drops with dreq", {28'h0, dack}, 32'h0);
    rd16(4'h4, v);
    chk("R11 address untouched", {16'h0, v}, 32'h0201);

    finish_run();
  end
endmodule